// File: doc/BRIEF.md
# Periodic Rate Divider with Interrupt Flag Register

This block turns a 32.768 kHz tick strobe into one of fifteen binary-divided periodic rates. The rate is chosen by a 4-bit code in the rate register, and code 0 stops it. Each periodic event sets a sticky periodic flag. When the square-wave enable is set, each periodic event also toggles a square-wave output.

Two more event inputs, alarm and update-ended, set their own sticky flags in the same flag byte. Bit 7 of that byte summarises every flag whose enable is set in the control register, and an active-low interrupt line follows it. Reading the flag byte clears it at the end of the read cycle. A host reaches the three registers through a simple register port: a write strobe, a read strobe and an address. Read data is combinational.

Top module: `rate_irq_unit`

## Requirements
- R1: After reset the rate register reads 0x26, the control register reads 0x00, the flag byte reads 0x00, `irq_no` is high and `sqw_o` is low.
- R2: The rate code is rate register bits 3:0. A code c from 1 to 15 gives one periodic event every 2^(c-1) ticks, on each tick whose 1-based count since reset is a multiple of 2^(c-1). Code 0 gives no periodic events.
- R3: The rate register is at address 0xA, the control register at 0xB and the flag byte at 0xC. Any other address reads 0x00. Writes to 0xC have no effect.
- R4: Flag byte bit 6 is the periodic flag, bit 5 the alarm flag and bit 4 the update-ended flag, and bits 3:0 read 0. Each flag is set by its event whatever the enables, and it stays set until it is cleared.
- R5: Flag byte bit 7 is 1 exactly when some flag is set together with its enable. The enables are control bit 6 (periodic), bit 5 (alarm) and bit 4 (update-ended).
- R6: When the flag byte is read with the read strobe, the read returns the pre-clear value, and all flags are 0 from the next cycle.
- R7: An event in the same cycle as a clearing read of the flag byte leaves its flag set after that cycle.
- R8: `irq_no` is low exactly when flag byte bit 7 is 1.
- R9: `sqw_o` toggles on each periodic event. It is forced low whenever control bit 3 is 0 or the rate code is 0.
- R10: Writes to the rate and control registers store all 8 bits, read back unchanged, and take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe at the 32.768 kHz reference rate |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (clears the flag byte when it is addressed) |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from the address |
| alarm_evt_i | input | 1 | Alarm event strobe |
| update_evt_i | input | 1 | Update-ended event strobe |
| irq_no | output | 1 | Interrupt request, active low |
| sqw_o | output | 1 | Square-wave output |

## Verification
Read data is due in the same cycle as the address, so the bench compares it 1 ns after driving the inputs and before the clock edge. Flags, bit 7, `irq_no` and `sqw_o` all change at the edge that samples the event, tick, write or clearing read. The bench therefore updates its model right after that edge and compares these outputs 1 ns later. Writes are first seen in the cycle after the strobe, so an event or tick in the write cycle still uses the old rate code and enables. The model follows that rule.

// File: rtl/rate_irq_pkg.sv
`timescale 1ns/1ps
package rate_irq_pkg;
  localparam int unsigned DATA_W = 8;
  localparam logic [3:0] ADDR_RATE = 4'hA;
  localparam logic [3:0] ADDR_CTRL = 4'hB;
  localparam logic [3:0] ADDR_FLAG = 4'hC;
  localparam int unsigned CTL_PER_EN = 6;
  localparam int unsigned CTL_ALM_EN = 5;
  localparam int unsigned CTL_UPD_EN = 4;
  localparam int unsigned CTL_SQW_EN = 3;
  localparam logic [DATA_W-1:0] RATE_RST = 8'h26;
  localparam logic [DATA_W-1:0] CTRL_RST = 8'h00;
  typedef struct packed {
    logic per;
    logic alm;
    logic upd;
  } evt_t;
endpackage

// File: rtl/rate_divider.sv
`timescale 1ns/1ps
module rate_divider #(
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             pulse_o
);
  localparam int unsigned NCODE = (1 << SEL_W) - 1;
  localparam int unsigned CNT_W = NCODE - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [NCODE:0]   tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  // tap[c]: this tick closes a period of 2^(c-1) ticks
  assign tap[0] = 1'b0;
  assign tap[1] = 1'b1;
  for (genvar c = 2; c <= NCODE; c++) begin : g_tap
    assign tap[c] = &cnt_q[c-2:0];
  end

  assign pulse_o = tick_i & tap[sel_i];
endmodule

// File: rtl/event_flag_reg.sv
`timescale 1ns/1ps
module event_flag_reg
  import rate_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  evt_t set_i,
  input  evt_t en_i,
  input  logic clr_i,
  output evt_t flag_o,
  output logic any_o
);
  evt_t flag_q;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (clr_i ? evt_t'('0) : flag_q) | set_i;
  end

  assign flag_o = flag_q;
  assign any_o  = |(flag_q & en_i);
endmodule

// File: rtl/square_wave_gen.sv
`timescale 1ns/1ps
module square_wave_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pulse_i,
  output logic sqw_o
);
  logic sqw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sqw_q <= 1'b0;
    else if (!en_i) sqw_q <= 1'b0;
    else if (pulse_i) sqw_q <= ~sqw_q;
  end

  assign sqw_o = sqw_q;
endmodule

// File: rtl/rate_irq_unit.sv
`timescale 1ns/1ps
module rate_irq_unit
  import rate_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned SEL_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              alarm_evt_i,
  input  logic              update_evt_i,
  output logic              irq_no,
  output logic              sqw_o
);
  logic [DATA_W-1:0] reg_a_q, reg_b_q;
  logic              hit_a, hit_b, hit_c;
  logic [SEL_W-1:0]  rate_code;
  logic              per_pulse, clr_c, sqw_en, sum;
  evt_t              set_v, en_v, flag_q;

  assign hit_a = (reg_addr_i == ADDR_W'(ADDR_RATE));
  assign hit_b = (reg_addr_i == ADDR_W'(ADDR_CTRL));
  assign hit_c = (reg_addr_i == ADDR_W'(ADDR_FLAG));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_a_q <= RATE_RST;
      reg_b_q <= CTRL_RST;
    end else if (reg_we_i) begin
      if (hit_a) reg_a_q <= reg_wdata_i;
      if (hit_b) reg_b_q <= reg_wdata_i;
    end
  end

  assign rate_code = reg_a_q[SEL_W-1:0];
  assign clr_c     = reg_re_i & hit_c;
  assign sqw_en    = reg_b_q[CTL_SQW_EN] & (rate_code != '0);
  assign set_v     = '{per: per_pulse, alm: alarm_evt_i, upd: update_evt_i};
  assign en_v      = '{per: reg_b_q[CTL_PER_EN], alm: reg_b_q[CTL_ALM_EN],
                       upd: reg_b_q[CTL_UPD_EN]};

  rate_divider #(.SEL_W(SEL_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .sel_i   (rate_code),
    .pulse_o (per_pulse)
  );

  event_flag_reg u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .en_i   (en_v),
    .clr_i  (clr_c),
    .flag_o (flag_q),
    .any_o  (sum)
  );

  square_wave_gen u_sqw (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (sqw_en),
    .pulse_i (per_pulse),
    .sqw_o   (sqw_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (hit_a)      reg_rdata_o = reg_a_q;
    else if (hit_b) reg_rdata_o = reg_b_q;
    else if (hit_c) reg_rdata_o = {sum, flag_q.per, flag_q.alm, flag_q.upd, 4'b0000};
  end

  assign irq_no = ~sum;
endmodule

// File: rtl/rate_irq_checker.sv
`timescale 1ns/1ps
module rate_irq_checker #(
  parameter int unsigned SEL_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             alarm_evt_i,
  input logic             update_evt_i,
  input logic             clr_c,
  input logic             per_pulse,
  input logic [2:0]       flag_q,
  input logic [SEL_W-1:0] rate_code,
  input logic             sqw_en,
  input logic             irq_no,
  input logic             sqw_o
);
  AST_RATE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_code == '0) |-> !per_pulse); // R2
  AST_ALARM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_evt_i |=> flag_q[1]); // R7
  AST_UPDATE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_evt_i |=> flag_q[0]); // R4
  AST_PER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_c && flag_q[2]) |=> flag_q[2]); // R4
  AST_CLEAR_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_c && !per_pulse && !alarm_evt_i && !update_evt_i) |=> (flag_q == 3'b000)); // R6
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> (flag_q != 3'b000)); // R8
  AST_SQW_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sqw_en |=> !sqw_o); // R9
endmodule

bind rate_irq_unit rate_irq_checker #(.SEL_W(SEL_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .alarm_evt_i  (alarm_evt_i),
  .update_evt_i (update_evt_i),
  .clr_c        (clr_c),
  .per_pulse    (per_pulse),
  .flag_q       (flag_q),
  .rate_code    (rate_code),
  .sqw_en       (sqw_en),
  .irq_no       (irq_no),
  .sqw_o        (sqw_o)
);

// File: tb/rate_irq_unit_bench.sv
`timescale 1ns/1ps
module rate_irq_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       we = 1'b0, re = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       alarm = 1'b0, upd = 1'b0;
  logic       irq_n, sqw;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  int         m_ticks = 0;
  logic [7:0] m_a = 8'h26, m_b = 8'h00;
  logic [2:0] m_f = 3'b000;   // {periodic, alarm, update}
  logic       m_sq = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  rate_irq_unit u_rate_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .alarm_evt_i(alarm), .update_evt_i(upd),
    .irq_no(irq_n), .sqw_o(sqw)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%02h expected=0x%02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [3:0] a);
    logic s;
    s = |(m_f & m_b[6:4]);
    case (a)
      4'hA:    return m_a;
      4'hB:    return m_b;
      4'hC:    return {s, m_f, 4'b0000};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_tag(input logic [3:0] a);
    if (a == 4'hA || a == 4'hB) return "R10 readback";
    if (a == 4'hC) return "R4 flag byte";
    return "R3 unmapped";
  endfunction

  // one clock: drive at negedge, check read data, clock, update model, check outputs
  task automatic step(input logic w, input logic r, input logic [3:0] ad,
                      input logic [7:0] wd, input logic tk, input logic al, input logic up);
    logic pev;
    logic [3:0] code;
    we = w; re = r; addr = ad; wdata = wd; tick = tk; alarm = al; upd = up;
    #1;
    check(rd_tag(ad), rdata, m_read(ad));
    @(posedge clk);
    code = m_a[3:0];
    pev = 1'b0;
    if (tk) begin
      m_ticks++;
      if (code != 0 && (m_ticks % (1 << (code - 1))) == 0) pev = 1'b1;
    end
    if (r && ad == 4'hC) m_f = 3'b000;
    m_f = m_f | {pev, al, up};
    if (!(m_b[3] && code != 0)) m_sq = 1'b0;
    else if (pev) m_sq = ~m_sq;
    if (w && ad == 4'hA) m_a = wd;
    if (w && ad == 4'hB) m_b = wd;
    #1;
    check("R8 irq line", {7'd0, irq_n}, {7'd0, ~(|(m_f & m_b[6:4]))});
    check("R9 square wave", {7'd0, sqw}, {7'd0, m_sq});
    @(negedge clk);
  endtask

  task automatic idle(); step(0, 0, 4'h0, 8'h00, 0, 0, 0); endtask
  task automatic wr(input logic [3:0] ad, input logic [7:0] d); step(1, 0, ad, d, 0, 0, 0); endtask

  task automatic peek(input logic [3:0] ad, input logic [7:0] exp, input string tag);
    we = 0; re = 0; addr = ad; tick = 0; alarm = 0; upd = 0;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic run_ticks(input int n, output int toggles);
    toggles = 0;
    for (int i = 0; i < n; i++) begin
      logic prev;
      prev = sqw;
      step(0, 0, 4'h0, 8'h00, 1, 0, 0);
      if (sqw !== prev) toggles++;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int tg;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    peek(4'hA, 8'h26, "R1 rate reset");
    peek(4'hB, 8'h00, "R1 ctrl reset");
    peek(4'hC, 8'h00, "R1 flag reset");
    check("R1 irq reset", {7'd0, irq_n}, 8'h01);
    check("R1 sqw reset", {7'd0, sqw}, 8'h00);
    // R3 map
    peek(4'h5, 8'h00, "R3 unmapped read");
    wr(4'hC, 8'hFF);
    peek(4'hC, 8'h00, "R3 flag write ignored");
    // R10 write/readback
    wr(4'hB, 8'h87);
    peek(4'hB, 8'h87, "R10 ctrl write");
    wr(4'hB, 8'h00);
    // R4 flag set without enable
    step(0, 0, 4'h0, 8'h00, 0, 1, 0);
    peek(4'hC, 8'h20, "R4 alarm flag no enable");
    check("R5 no summary when disabled", {7'd0, irq_n}, 8'h01);
    // R5 enable makes summary
    wr(4'hB, 8'h20);
    peek(4'hC, 8'hA0, "R5 summary with enable");
    check("R8 irq asserted", {7'd0, irq_n}, 8'h00);
    // R6 clear on read
    step(0, 1, 4'hC, 8'h00, 0, 0, 0);
    peek(4'hC, 8'h00, "R6 cleared after read");
    check("R6 irq released", {7'd0, irq_n}, 8'h01);
    // R7 event during read
    step(0, 1, 4'hC, 8'h00, 0, 0, 1);
    peek(4'hC, 8'h10, "R7 update kept over clear");
    step(0, 1, 4'hC, 8'h00, 0, 1, 0);
    peek(4'hC, 8'hA0, "R7 alarm kept over clear");
    step(0, 1, 4'hC, 8'h00, 0, 0, 0);
    // R2 code 3: period 4 ticks
    wr(4'hB, 8'h08);
    wr(4'hA, 8'h23);
    run_ticks(64, tg);
    check("R2 code 3 events in 64 ticks", 8'(tg), 8'd16);
    wr(4'hA, 8'h21);
    run_ticks(10, tg);
    check("R2 code 1 events in 10 ticks", 8'(tg), 8'd10);
    // R9 / R2 code 0
    wr(4'hA, 8'h20);
    step(0, 1, 4'hC, 8'h00, 1, 0, 0);
    check("R9 low with code 0", {7'd0, sqw}, 8'h00);
    run_ticks(20, tg);
    check("R2 code 0 no events", 8'(tg), 8'd0);
    peek(4'hC, 8'h00, "R2 code 0 no periodic flag");
    // R9 enable off, R5 periodic summary
    wr(4'hA, 8'h26);
    wr(4'hB, 8'h40);
    run_ticks(100, tg);
    check("R9 low with sqw disabled", 8'(tg), 8'd0);
    peek(4'hC, 8'hC0, "R5 periodic summary");
    check("R8 irq from periodic", {7'd0, irq_n}, 8'h00);
    step(0, 1, 4'hC, 8'h00, 0, 0, 0);
    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic w, rd;
      logic [3:0] ad;
      logic [7:0] d;
      r = int'($urandom_range(0, 15));
      w = (r == 0);
      rd = (r == 1) || (r == 2);
      ad = (r == 0) ? (($urandom_range(0, 1) == 0) ? 4'hA : 4'hB) :
           (rd ? 4'hC : 4'(9 + $urandom_range(0, 4)));
      d = (ad == 4'hA) ? {4'h2, 4'($urandom_range(0, 6))} : 8'($urandom_range(0, 255));
      step(w, rd, ad, d, $urandom_range(0, 3) != 0, $urandom_range(0, 40) == 0,
           $urandom_range(0, 40) == 0);
    end
    // R2 slowest code: one event per 16384 ticks
    wr(4'hA, 8'h2F);
    wr(4'hB, 8'h48);
    run_ticks(16384, tg);
    check("R2 code 15 events in 16384 ticks", 8'(tg), 8'd1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule